// File: doc/BRIEF.md
# Palette VGA Timing Generator

This block produces a 640x480 raster from a fast system clock. An internal divider issues one pixel-enable strobe every `CLK_DIV` clocks (8 by default, giving 25 MHz pixels from 200 MHz). Horizontal and vertical counters advance on that strobe and walk each line and each frame through its blanking, sync and visible regions. For every visible position the block raises a one-cycle request, and an external pixel source answers with an 8-bit colour index.

The index selects one of 256 palette entries. Each entry is a 24-bit colour that software loads through a separate write port. The looked-up colour is scaled per channel by an intensity level, unless scaling is bypassed. It is then driven as 8-bit red, green and blue, together with a blanking flag, sync outputs and a frame-start marker. All of these are aligned to the same pixel.

Sync can be driven on two pins, or as a composite signal on the horizontal pin alone. In composite mode the horizontal sync polarity is inverted for the whole vertical sync interval.

Top module: `vga_palette_timing`

## Requirements
- R1: A line is 800 pixel periods, numbered 0 to 799. Horizontal sync is active for pixels 16 to 111 of every line, blank or visible. The visible pixels are 160 to 799.
- R2: A frame is 525 lines, numbered 0 to 524. The visible lines are 33 to 512. Vertical sync is active on lines 523 and 524 and inactive on all other lines.
- R3: `pix_tick` is high for exactly one clock in every `CLK_DIV` clocks. The first strobe comes `CLK_DIV-1` clocks after reset is released. The counters start at line 0, pixel 0.
- R4: `pix_req` is high only in a `pix_tick` cycle, and only when the counters are at a visible position. The source must hold `pix_idx` valid at the next `pix_tick` edge.
- R5: Colour, `blank_o`, both syncs and `frame_start` for a position appear together just after the pixel-enable edge that follows the edge of that position's request. They hold for one pixel period.
- R6: The palette has 256 entries, addressed by the 8-bit index. A write word carries red in bits 31:24, green in bits 23:16 and blue in bits 15:8. Bits 7:0 are ignored.
- R7: A palette write in the same clock as a palette read at the same address returns the old entry to that read. The new entry is seen by later reads.
- R8: When scaling is enabled, each channel output equals floor(c*k/128), where k is `intensity`. A k above 128 acts as 128, so 128 passes the colour through unchanged.
- R9: With `scale_bypass` high, the palette colour is output unchanged whatever the value of `intensity`.
- R10: Red, green and blue are zero whenever `blank_o` is high, that is, outside the visible region.
- R11: Both syncs are active-low. `hs_invert` and `vs_invert` each invert their own pin.
- R12: With `csync_en` high, `hsync_o` carries horizontal sync XOR vertical sync, then inverted by `hs_invert`. `vsync_o` is held at its inactive level.
- R13: `frame_start` is high for one pixel period, at pixel 160 of line 33, the first visible pixel of the frame.
- R14: During reset, `blank_o` is 1, the colour outputs are 0, `pix_req` and `frame_start` are 0, and both syncs sit at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_tick | output | 1 | Pixel-enable strobe |
| pix_req | output | 1 | Request for the index of the current visible position |
| pix_idx | input | 8 | Colour index from the pixel source |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | 8 | Palette write address |
| pal_wdata | input | 32 | Palette write word, RGB in bits 31:8 |
| intensity | input | 8 | Channel scale level, 0 to 128 |
| scale_bypass | input | 1 | Skip intensity scaling |
| hs_invert | input | 1 | Invert the horizontal sync pin |
| vs_invert | input | 1 | Invert the vertical sync pin |
| csync_en | input | 1 | Composite sync on the horizontal pin |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel |
| blank_o | output | 1 | High outside the visible region |
| hsync_o | output | 1 | Horizontal or composite sync |
| vsync_o | output | 1 | Vertical sync |
| frame_start | output | 1 | First visible pixel of the frame |

## Verification
The bench builds the block with a divider of 2 and a shrunken raster: 2+3+2+4 pixels per line and 2+3+1+2 lines per frame. This keeps the region order and every boundary of the full-size timing, but one frame takes only 176 clocks. Seven complete frames can therefore be compared pixel by pixel against an arithmetic model. Each frame runs under a different setting: full, half and zero intensity, an over-range level, bypass, composite sync, and inverted polarities. The full 256-entry palette is loaded through the write port. The last frame rewrites the very entry being read on every pixel-enable edge.

// File: rtl/vga_pal_pkg.sv
// Shared types for the palette VGA timing generator.
// Assumes 8-bit colour channels; index 2 is red, 1 is green, 0 is blue.
package vga_pal_pkg;

    typedef logic [2:0][7:0] rgb_t;

    typedef struct packed {
        logic blank;
        logic hs_act;
        logic vs_act;
        logic fstart;
    } vid_ctl_t;

    localparam vid_ctl_t CTL_IDLE = '{blank: 1'b1, hs_act: 1'b0, vs_act: 1'b0, fstart: 1'b0};

endpackage

// File: rtl/vga_raster_counter.sv
// Pixel-enable divider plus horizontal and vertical position counters.
// Line order: front porch, sync, back porch, visible.
// Frame order: top blank, visible, bottom blank, sync.
// Assumes CLK_DIV >= 2 so that every strobe is followed by an idle clock.
module vga_raster_counter #(
    parameter int CLK_DIV = 8,
    parameter int H_FP    = 16,
    parameter int H_SYNC  = 96,
    parameter int H_BP    = 48,
    parameter int H_ACT   = 640,
    parameter int V_TOP   = 33,
    parameter int V_ACT   = 480,
    parameter int V_BOT   = 10,
    parameter int V_SYNC  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic                  pix_tick,
    output logic                  visible,
    output vga_pal_pkg::vid_ctl_t ctl_now
);
    localparam int H_TOTAL = H_FP + H_SYNC + H_BP + H_ACT;
    localparam int V_TOTAL = V_TOP + V_ACT + V_BOT + V_SYNC;
    localparam int DW      = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);

    localparam logic [DW-1:0] DIV_LAST   = DW'(CLK_DIV - 1);
    localparam logic [HW-1:0] HS_BEG     = HW'(H_FP);
    localparam logic [HW-1:0] HS_END     = HW'(H_FP + H_SYNC);
    localparam logic [HW-1:0] H_VIS_BEG  = HW'(H_FP + H_SYNC + H_BP);
    localparam logic [HW-1:0] H_LAST     = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_VIS_BEG  = VW'(V_TOP);
    localparam logic [VW-1:0] V_VIS_END  = VW'(V_TOP + V_ACT);
    localparam logic [VW-1:0] VS_BEG     = VW'(V_TOP + V_ACT + V_BOT);
    localparam logic [VW-1:0] V_LAST     = VW'(V_TOTAL - 1);

    logic [DW-1:0] div_q;
    logic [HW-1:0] hc_q;
    logic [VW-1:0] vc_q;
    logic          h_vis, v_vis;

    assign pix_tick = (div_q == DIV_LAST);

    // Divide the system clock down to the pixel rate.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (pix_tick) div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end

    // Step the pixel and line counters once per pixel period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc_q <= '0;
            vc_q <= '0;
        end else if (pix_tick) begin
            if (hc_q == H_LAST) begin
                hc_q <= '0;
                vc_q <= (vc_q == V_LAST) ? '0 : vc_q + 1'b1;
            end else begin
                hc_q <= hc_q + 1'b1;
            end
        end
    end

    // Decode the region flags for the current position.
    always_comb begin
        h_vis          = (hc_q >= H_VIS_BEG);
        v_vis          = (vc_q >= V_VIS_BEG) && (vc_q < V_VIS_END);
        visible        = h_vis && v_vis;
        ctl_now.blank  = !visible;
        ctl_now.hs_act = (hc_q >= HS_BEG) && (hc_q < HS_END);
        ctl_now.vs_act = (vc_q >= VS_BEG);
        ctl_now.fstart = (hc_q == H_VIS_BEG) && (vc_q == V_VIS_BEG);
    end

endmodule

// File: rtl/vga_palette_ram.sv
// Colour palette: one write port and one registered read port.
// A read and a write to the same address in one clock return the old entry.
module vga_palette_ram #(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  vga_pal_pkg::rgb_t  wdata,
    input  logic               re,
    input  logic [IDX_W-1:0]   raddr,
    output vga_pal_pkg::rgb_t  rdata
);
    localparam int DEPTH = 1 << IDX_W;

    vga_pal_pkg::rgb_t mem [DEPTH];

    // Store a palette entry.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Fetch the entry for the current index on each pixel strobe.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/vga_intensity_scale.sv
// Per-channel scaling: out = floor(c * level / FULL), with the level clamped to FULL.
// Assumes FULL is a power of two, so the divide is a shift.
module vga_intensity_scale #(
    parameter int LVL_W = 8,
    parameter int FULL  = 128
) (
    input  vga_pal_pkg::rgb_t din,
    input  logic [LVL_W-1:0]  level,
    input  logic              bypass,
    output vga_pal_pkg::rgb_t dout
);
    localparam int                SHIFT  = $clog2(FULL);
    localparam int                PW     = 8 + LVL_W;
    localparam logic [LVL_W-1:0]  FULL_L = LVL_W'(FULL);

    logic [LVL_W-1:0] lvl_eff;

    // Clamp an over-range level to full scale.
    assign lvl_eff = (level > FULL_L) ? FULL_L : level;

    for (genvar c = 0; c < 3; c++) begin : g_chan
        logic [PW-1:0] prod;
        // Multiply this channel, then shift the result back to 8 bits.
        assign prod    = PW'(din[c]) * PW'(lvl_eff);
        assign dout[c] = bypass ? din[c] : 8'(prod >> SHIFT);
    end

endmodule

// File: rtl/vga_palette_timing.sv
// Top of the palette VGA generator: counters, palette lookup, scaling and sync shaping.
// Control is delayed by two pixel strobes to line up with the registered palette read.
// Assumes the pixel source holds pix_idx from a request until the next strobe.
module vga_palette_timing #(
    parameter int CLK_DIV = 8,
    parameter int H_FP    = 16,
    parameter int H_SYNC  = 96,
    parameter int H_BP    = 48,
    parameter int H_ACT   = 640,
    parameter int V_TOP   = 33,
    parameter int V_ACT   = 480,
    parameter int V_BOT   = 10,
    parameter int V_SYNC  = 2,
    parameter int IDX_W   = 8,
    parameter int LVL_W   = 8,
    parameter int FULL    = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              pix_tick,
    output logic              pix_req,
    input  logic [IDX_W-1:0]  pix_idx,
    input  logic              pal_we,
    input  logic [IDX_W-1:0]  pal_addr,
    input  logic [31:0]       pal_wdata,
    input  logic [LVL_W-1:0]  intensity,
    input  logic              scale_bypass,
    input  logic              hs_invert,
    input  logic              vs_invert,
    input  logic              csync_en,
    output logic [7:0]        red,
    output logic [7:0]        green,
    output logic [7:0]        blue,
    output logic              blank_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              frame_start
);
    import vga_pal_pkg::*;

    logic     visible;
    vid_ctl_t ctl_now, ctl_s1, ctl_s2;
    rgb_t     pal_rd, scaled;
    logic     pal_low_unused;

    assign pal_low_unused = ^pal_wdata[7:0];

    vga_raster_counter #(
        .CLK_DIV(CLK_DIV), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP), .H_ACT(H_ACT),
        .V_TOP(V_TOP), .V_ACT(V_ACT), .V_BOT(V_BOT), .V_SYNC(V_SYNC)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .visible(visible), .ctl_now(ctl_now)
    );

    assign pix_req = pix_tick && visible;

    vga_palette_ram #(.IDX_W(IDX_W)) u_pal (
        .clk(clk), .we(pal_we), .waddr(pal_addr), .wdata(pal_wdata[31:8]),
        .re(pix_tick), .raddr(pix_idx), .rdata(pal_rd)
    );

    vga_intensity_scale #(.LVL_W(LVL_W), .FULL(FULL)) u_scale (
        .din(pal_rd), .level(intensity), .bypass(scale_bypass), .dout(scaled)
    );

    // Delay the region flags two pixel periods to match the palette read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_s1 <= CTL_IDLE;
            ctl_s2 <= CTL_IDLE;
        end else if (pix_tick) begin
            ctl_s1 <= ctl_now;
            ctl_s2 <= ctl_s1;
        end
    end

    // Drive the colour, blanked to black outside the visible region.
    always_comb begin
        {red, green, blue} = ctl_s2.blank ? 24'h0 : {scaled[2], scaled[1], scaled[0]};
        blank_o            = ctl_s2.blank;
        frame_start        = ctl_s2.fstart;
    end

    // Shape both sync pins for polarity and the composite mode.
    always_comb begin
        if (csync_en) begin
            hsync_o = ~(ctl_s2.hs_act ^ ctl_s2.vs_act) ^ hs_invert;
            vsync_o = ~vs_invert;
        end else begin
            hsync_o = ~ctl_s2.hs_act ^ hs_invert;
            vsync_o = ~ctl_s2.vs_act ^ vs_invert;
        end
    end

endmodule

// File: rtl/vga_palette_timing_chk.sv
// Temporal checks on the ports of vga_palette_timing, attached by bind.
module vga_palette_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic pix_tick,
    input logic blank_o,
    input logic hsync_o,
    input logic vsync_o,
    input logic frame_start,
    input logic csync_en,
    input logic hs_invert,
    input logic vs_invert
);
    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pix_tick) |-> $stable(blank_o));

    // R13
    fstart_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !blank_o);

    // R13
    fstart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_tick && frame_start) |=> !frame_start);

    // R2
    vsync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!csync_en && (vsync_o == vs_invert)) |-> blank_o);

    // R1
    hsync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!csync_en && (hsync_o == hs_invert)) |-> blank_o);

endmodule

bind vga_palette_timing vga_palette_timing_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .blank_o(blank_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .frame_start(frame_start),
    .csync_en(csync_en), .hs_invert(hs_invert), .vs_invert(vs_invert)
);

// File: tb/sim_vga_palette_timing.sv
module sim_vga_palette_timing;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CD = 2;
    localparam int HFP = 2, HSY = 3, HBP = 2, HAC = 4;
    localparam int VTP = 2, VAC = 3, VBT = 1, VSY = 2;
    localparam int HT = HFP + HSY + HBP + HAC;
    localparam int VT = VTP + VAC + VBT + VSY;
    localparam int FRAME = HT * VT;
    localparam int NFR = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_tick, pix_req;
    logic [7:0]  pix_idx = 8'd0;
    logic        pal_we = 1'b0;
    logic [7:0]  pal_addr = 8'd0;
    logic [31:0] pal_wdata = 32'd0;
    logic [7:0]  intensity = 8'd128;
    logic        scale_bypass = 1'b0, hs_invert = 1'b0, vs_invert = 1'b0, csync_en = 1'b0;
    logic [7:0]  red, green, blue;
    logic        blank_o, hsync_o, vsync_o, frame_start;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [23:0] pal_m [256];

    always #2 clk = ~clk;

    vga_palette_timing #(
        .CLK_DIV(CD), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP), .H_ACT(HAC),
        .V_TOP(VTP), .V_ACT(VAC), .V_BOT(VBT), .V_SYNC(VSY)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .pix_req(pix_req), .pix_idx(pix_idx),
        .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata), .intensity(intensity),
        .scale_bypass(scale_bypass), .hs_invert(hs_invert), .vs_invert(vs_invert),
        .csync_en(csync_en), .red(red), .green(green), .blue(blue), .blank_o(blank_o),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .frame_start(frame_start)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int hpos(int n); return n % HT; endfunction
    function automatic int vpos(int n); return (n / HT) % VT; endfunction
    function automatic bit vis(int n);
        return hpos(n) >= HFP + HSY + HBP && vpos(n) >= VTP && vpos(n) < VTP + VAC;
    endfunction
    function automatic bit hs_on(int n); return hpos(n) >= HFP && hpos(n) < HFP + HSY; endfunction
    function automatic bit vs_on(int n); return vpos(n) >= VTP + VAC + VBT; endfunction
    function automatic bit fs_on(int n); return hpos(n) == HFP + HSY + HBP && vpos(n) == VTP; endfunction
    function automatic logic [7:0] idx_of(int n);
        return 8'((hpos(n) * 13 + vpos(n) * 71 + (n / FRAME) * 53) & 255);
    endfunction
    function automatic logic [7:0] scl(logic [7:0] c);
        int k;
        if (scale_bypass) return c;
        k = (intensity > 8'd128) ? 128 : int'(intensity);
        return 8'((int'(c) * k) / 128);
    endfunction

    // Settings per frame: 0 full, 1 half, 2 bypass, 3 over-range, 4 composite at zero, 5 composite inverted, 6 inverted with writes
    task automatic apply_cfg(input int fr);
        intensity    = (fr == 1) ? 8'd64 : (fr == 2) ? 8'd37 : (fr == 3) ? 8'd200 :
                       (fr == 4) ? 8'd0 : (fr == 6) ? 8'd96 : 8'd128;
        scale_bypass = (fr == 2);
        csync_en     = (fr == 4) || (fr == 5);
        hs_invert    = (fr >= 5);
        vs_invert    = (fr >= 5);
    endtask

    task automatic check_pos(input int n, input logic [23:0] raw);
        int fr;
        string ctag;
        logic [23:0] exp_rgb;
        logic exp_hs, exp_vs;
        fr = n / FRAME;
        ctag = (fr == 0 || fr == 5) ? "R6 colour" : (fr == 2) ? "R9 bypass" :
               (fr == 6) ? "R7 same-cycle write" : "R8 scale";
        exp_rgb = vis(n) ? {scl(raw[23:16]), scl(raw[15:8]), scl(raw[7:0])} : 24'h0;
        chk(vis(n) ? ctag : "R10 blank colour", {8'h0, red, green, blue}, {8'h0, exp_rgb});
        chk("R5 blank", 32'(blank_o), 32'(!vis(n)));
        if (csync_en) begin
            exp_hs = ~(hs_on(n) ^ vs_on(n)) ^ hs_invert;
            exp_vs = ~vs_invert;
            chk("R12 csync", 32'(hsync_o), 32'(exp_hs));
            chk("R12 vsync idle", 32'(vsync_o), 32'(exp_vs));
        end else begin
            exp_hs = ~hs_on(n) ^ hs_invert;
            exp_vs = ~vs_on(n) ^ vs_invert;
            chk(hs_invert ? "R11 hsync" : "R1 hsync", 32'(hsync_o), 32'(exp_hs));
            chk(vs_invert ? "R11 vsync" : "R2 vsync", 32'(vsync_o), 32'(exp_vs));
        end
        chk("R13 frame start", 32'(frame_start), 32'(fs_on(n)));
    endtask

    initial begin
        int j, cyc;
        bit pend, tk;
        logic [7:0] pend_idx;
        logic [23:0] raw;
        logic [31:0] wd;
        j = -1; cyc = 0; pend = 0; pend_idx = 0; raw = 0;
        for (int i = 0; i < 256; i++)
            pal_m[i] = {8'(i * 5 + 1), 8'(i) ^ 8'h3c, 8'(255 - i)};
        // R6: load the palette with junk in the low byte
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            pal_we = 1'b1; pal_addr = 8'(i); pal_wdata = {pal_m[i], 8'ha5};
        end
        @(negedge clk);
        pal_we = 1'b0;
        #1;
        // R14: reset state
        chk("R14 blank", 32'(blank_o), 32'd1);
        chk("R14 colour", {8'h0, red, green, blue}, 32'd0);
        chk("R14 hsync", 32'(hsync_o), 32'd1);
        chk("R14 vsync", 32'(vsync_o), 32'd1);
        chk("R14 req", 32'(pix_req), 32'd0);
        chk("R14 frame start", 32'(frame_start), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (pend) begin pix_idx = pend_idx; pend = 0; end
            pal_we = 1'b0;
            tk = pix_tick;
            chk("R3 tick", 32'(tk), 32'((cyc % CD) == CD - 1));
            if (tk) begin
                j++;
                if (j >= 2) apply_cfg((j - 2) / FRAME);
                #1;
                if (j >= 2) check_pos(j - 2, raw);
                chk("R4 request", 32'(pix_req), 32'(vis(j)));
                raw = pal_m[pix_idx];
                if (j >= 2 && (j - 2) / FRAME == 6) begin
                    // R7: overwrite the entry being read at this edge
                    wd = $urandom;
                    pal_we = 1'b1; pal_addr = pix_idx; pal_wdata = wd;
                    pal_m[pix_idx] = wd[31:8];
                end
                if (pix_req) begin pend = 1; pend_idx = idx_of(j); end
                if (j - 2 >= NFR * FRAME - 1) done = 1;
            end else begin
                #1;
                chk("R4 request idle", 32'(pix_req), 32'd0);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule